// File: doc/BRIEF.md
# Alarm Match and Status Flag Unit

This unit sits beside a calendar clock's counters. It keeps six alarm registers (seconds, minutes, hour, date, month, weekday). Each register has its own compare-enable bit. On every second tick it checks whether all enabled alarm fields equal the running BCD time. When they do, it raises a sticky alarm flag in an eight-bit status byte.

The unit also owns the clear rules for that status byte:
- A host write can only clear the clearable flags.
- An optional auto-clear drops the alarm and supply-warning flags when a status read completes.
- The daylight-saving-adjusted flag clears on a completed status read, or when the month changes.
- Any flag event that arrives while a status read is open survives that read.
- A fail flag is set at reset and clears on the first write to a time register.

An interrupt level follows the alarm flag when the interrupt enable is set.

A host access is a write strobe with address and data, or a read strobe followed later by a read-complete pulse. The read strobe opens the read and the read-complete pulse closes it. Only the read-complete pulse causes any clearing, so the byte the host samples stays stable while the read is open.

Top module: `rtc_alarm_status`

## Requirements
- R1: After reset the status byte reads 01h and the interrupt output is 0.
- R2: A second tick on which every enabled alarm field equals its time field sets status bit 4 (alarm), visible from the cycle after the tick. Alarm registers are at 10h (seconds), 11h (minutes), 12h (hour), 13h (date), 14h (month) and 15h (weekday). In each, bit 7 is the compare enable and bits 6..0 hold the value.
- R3: The alarm flag does not set:
  - without a tick;
  - when an enabled field differs from its time field;
  - when no field is enabled.
  A field whose enable bit is 0 does not affect the match.
- R4: A write to 07h replaces bits 6, 4, 3, 2 and 1 with their old value ANDed with the write data, so writing 1 never sets a flag. Bits 7, 5 and 0 are unaffected by that write.
- R5: A completed status read is a read strobe at 07h followed by a read-complete pulse. When control bit 7 (register 08h) is 1, a completed status read clears those of bits 4, 3, 2 and 1 that were set when the read began. When control bit 7 is 0, it leaves them. Clearing happens on the read-complete pulse, not on the read strobe.
- R6: A flag whose set event occurs anywhere from the read strobe cycle through the read-complete cycle stays set after that read completes.
- R7: Bit 5 (DST adjusted) is set by the DST event input. A completed status read clears it, whatever the auto-clear bit holds, and it is still set between the read strobe and the read-complete pulse. A month-change pulse also clears it.
- R8: The interrupt output equals status bit 4 AND control bit 6 (register 08h).
- R9: Bit 0 (RTC fail) is 1 after reset. It clears on any write to addresses 00h..06h, is unaffected by writes elsewhere, and never sets again until reset.
- R10: The low-VDD, low-battery-85, low-battery-75 and oscillator-stop event inputs set bits 3, 2, 1 and 6 respectively, and these bits stay set. The busy input appears at bit 7 in the same cycle.
- R11: When a set event and any clear arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_sec | input | 1 | One-cycle pulse once per second |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hour, BCD with mode bits |
| cur_date | input | 7 | Current date, BCD |
| cur_month | input | 7 | Current month, BCD |
| cur_wday | input | 7 | Current weekday |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, opens a read |
| bus_rd_done | input | 1 | Read-complete pulse, closes a read |
| ev_lvdd | input | 1 | Low main supply event |
| ev_lbat85 | input | 1 | Battery below 85% trip event |
| ev_lbat75 | input | 1 | Battery below 75% trip event |
| ev_osc_stop | input | 1 | Oscillator stopped event |
| ev_dst | input | 1 | Daylight-saving adjustment event |
| ev_month | input | 1 | Month rollover pulse |
| busy_in | input | 1 | Temperature conversion in progress |
| status | output | 8 | Status byte |
| alarm_irq | output | 1 | Alarm interrupt level |

## Verification
Every flag, alarm-register and control result is registered once. The effect of a tick, write, event or read-complete pulse is therefore due one clock after the edge that captures it. The interrupt follows the alarm flag and the control bit with no extra delay. Busy is combinational, so it is checked a moment after the input changes, before any edge.

The bench drives inputs on the falling edge and lets exactly one rising edge pass before it samples. Each result is read at the next falling edge. Read-window cases sample between the strobe and the completion pulse as well, to show that nothing clears early.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int SR_ADDR    = 'h07;
  localparam int CTRL_ADDR  = 'h08;
  localparam int ALM_BASE   = 'h10;
  localparam int RTC_LAST   = 'h06;
  // status bit positions
  localparam int B_BUSY = 7;
  localparam int B_OSCF = 6;
  localparam int B_DST  = 5;
  localparam int B_ALM  = 4;
  localparam int B_LVDD = 3;
  localparam int B_LB85 = 2;
  localparam int B_LB75 = 1;
  localparam int B_RTCF = 0;
  // control bit positions
  localparam int C_AUTO  = 7;
  localparam int C_IRQEN = 6;
  // flag groups
  localparam logic [7:0] WCLR_MASK = 8'b0101_1110;
  localparam logic [7:0] AUTO_MASK = 8'b0001_1110;
  localparam logic [7:0] DST_MASK  = 8'b0010_0000;
  localparam logic [7:0] FAIL_MASK = 8'b0000_0001;
endpackage

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  parameter int FIELD_W = 7
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                   wdata,
  input  logic                                wr_en,
  output logic [NUM_FIELDS-1:0]               alm_en,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]  alm_val,
  output logic                                auto_clr,
  output logic                                irq_en,
  output logic                                rtc_wr
);
  localparam int EN_BIT = DATA_W - 1;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    logic               sel;
    logic               en_d;
    logic [FIELD_W-1:0] val_d;

    always_comb begin
      sel   = wr_en && (addr == ADDR_W'(ALM_BASE + i));
      en_d  = wdata[EN_BIT];
      val_d = wdata[FIELD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alm_en[i]  <= 1'b0;
        alm_val[i] <= '0;
      end else if (sel) begin
        alm_en[i]  <= en_d;
        alm_val[i] <= val_d;
      end
    end
  end

  logic ctrl_sel;
  always_comb begin
    ctrl_sel = wr_en && (addr == ADDR_W'(CTRL_ADDR));
    rtc_wr   = wr_en && (addr <= ADDR_W'(RTC_LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_clr <= 1'b0;
      irq_en   <= 1'b0;
    end else if (ctrl_sel) begin
      auto_clr <= wdata[C_AUTO];
      irq_en   <= wdata[C_IRQEN];
    end
  end
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
#(
  parameter int FIELD_W = 7
) (
  input  logic                                tick,
  input  logic [NUM_FIELDS-1:0]               alm_en,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  alm_val,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  cur,
  output logic                                hit
);
  logic [NUM_FIELDS-1:0] field_ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    // a disabled field never blocks the match
    assign field_ok[i] = !alm_en[i] || (alm_val[i] == cur[i]);
  end

  assign hit = tick && (|alm_en) && (&field_ok);
endmodule

// File: rtl/alm_flags.sv
module alm_flags
  import alm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_start,
  input  logic              rd_done,
  input  logic              auto_clr,
  input  logic              set_alm,
  input  logic              set_lvdd,
  input  logic              set_lb85,
  input  logic              set_lb75,
  input  logic              set_oscf,
  input  logic              set_dst,
  input  logic              month_tick,
  input  logic              rtc_wr,
  input  logic              busy,
  output logic [DATA_W-1:0] status
);
  logic [DATA_W-1:0] flg_q,  flg_d;
  logic [DATA_W-1:0] snap_q, snap_d;
  logic [DATA_W-1:0] hit_q,  hit_d;
  logic              open_q, open_d;
  logic [DATA_W-1:0] set_vec, wr_clr, rd_clr, mon_clr, fail_clr, keep;
  logic              fin;

  always_comb begin
    set_vec         = '0;
    set_vec[B_OSCF] = set_oscf;
    set_vec[B_DST]  = set_dst;
    set_vec[B_ALM]  = set_alm;
    set_vec[B_LVDD] = set_lvdd;
    set_vec[B_LB85] = set_lb85;
    set_vec[B_LB75] = set_lb75;

    fin      = rd_done && open_q;
    keep     = hit_q | set_vec;
    wr_clr   = sr_wr ? (~wdata & WCLR_MASK) : '0;
    rd_clr   = '0;
    if (fin) begin
      rd_clr = snap_q & DST_MASK;
      if (auto_clr) rd_clr = rd_clr | (snap_q & AUTO_MASK);
      rd_clr = rd_clr & ~keep;
    end
    mon_clr  = month_tick ? DST_MASK : '0;
    fail_clr = rtc_wr ? FAIL_MASK : '0;

    // sets are applied last so they win against any clear
    flg_d = (flg_q & ~(wr_clr | rd_clr | mon_clr | fail_clr)) | set_vec;

    open_d = open_q;
    snap_d = snap_q;
    hit_d  = hit_q;
    if (rd_start) begin
      open_d = 1'b1;
      snap_d = flg_q;
      hit_d  = set_vec;
    end else if (open_q) begin
      hit_d = hit_q | set_vec;
      if (rd_done) open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q  <= FAIL_MASK;
      snap_q <= '0;
      hit_q  <= '0;
      open_q <= 1'b0;
    end else begin
      flg_q  <= flg_d;
      snap_q <= snap_d;
      hit_q  <= hit_d;
      open_q <= open_d;
    end
  end

  always_comb begin
    status         = flg_q;
    status[B_BUSY] = busy;
  end
endmodule

// File: rtl/rtc_alarm_status.sv
module rtc_alarm_status
  import alm_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  parameter int FIELD_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_sec,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_hour,
  input  logic [FIELD_W-1:0] cur_date,
  input  logic [FIELD_W-1:0] cur_month,
  input  logic [FIELD_W-1:0] cur_wday,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_rd_done,
  input  logic               ev_lvdd,
  input  logic               ev_lbat85,
  input  logic               ev_lbat75,
  input  logic               ev_osc_stop,
  input  logic               ev_dst,
  input  logic               ev_month,
  input  logic               busy_in,
  output logic [DATA_W-1:0]  status,
  output logic               alarm_irq
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  logic [NUM_FIELDS-1:0]              alm_en;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm_val;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] cur;
  logic auto_clr, irq_en, rtc_wr, match_hit, sr_wr, sr_rd;

  always_comb begin
    cur[0] = cur_sec;
    cur[1] = cur_min;
    cur[2] = cur_hour;
    cur[3] = cur_date;
    cur[4] = cur_month;
    cur[5] = cur_wday;
    sr_wr  = bus_wr && (bus_addr == ADDR_W'(SR_ADDR));
    sr_rd  = bus_rd && (bus_addr == ADDR_W'(SR_ADDR));
  end

  alm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W)) i_regs (
    .clk(clk), .rst_n(rst_int_n), .addr(bus_addr), .wdata(bus_wdata),
    .wr_en(bus_wr), .alm_en(alm_en), .alm_val(alm_val),
    .auto_clr(auto_clr), .irq_en(irq_en), .rtc_wr(rtc_wr)
  );

  alm_match #(.FIELD_W(FIELD_W)) i_match (
    .tick(tick_sec), .alm_en(alm_en), .alm_val(alm_val), .cur(cur),
    .hit(match_hit)
  );

  alm_flags #(.DATA_W(DATA_W)) i_flags (
    .clk(clk), .rst_n(rst_int_n), .sr_wr(sr_wr), .wdata(bus_wdata),
    .rd_start(sr_rd), .rd_done(bus_rd_done), .auto_clr(auto_clr),
    .set_alm(match_hit), .set_lvdd(ev_lvdd), .set_lb85(ev_lbat85),
    .set_lb75(ev_lbat75), .set_oscf(ev_osc_stop), .set_dst(ev_dst),
    .month_tick(ev_month), .rtc_wr(rtc_wr), .busy(busy_in),
    .status(status)
  );

  assign alarm_irq = status[B_ALM] && irq_en;
endmodule

// File: rtl/alm_checker.sv
module alm_checker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_sec,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              ev_lvdd,
  input logic              ev_dst,
  input logic              ev_month,
  input logic [DATA_W-1:0] status,
  input logic              alarm_irq
);
  assert_alarm_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> $past(tick_sec));

  assert_write_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(7) && !tick_sec) |=> !$rose(status[4]));

  assert_month_clears_dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_month && !ev_dst) |=> !status[5]);

  assert_dst_needs_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> $past(ev_dst));

  assert_irq_needs_alarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> status[4]);

  assert_fail_never_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(status[0]));

  assert_lvdd_needs_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $past(ev_lvdd));
endmodule

bind rtc_alarm_status alm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_alm_checker (
  .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .ev_lvdd(ev_lvdd), .ev_dst(ev_dst), .ev_month(ev_month),
  .status(status), .alarm_irq(alarm_irq)
);

// File: tb/test_rtc_alarm_status.sv
module test_rtc_alarm_status;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_sec;
  logic [6:0] cur_sec, cur_min, cur_hour, cur_date, cur_month, cur_wday;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr, bus_rd, bus_rd_done;
  logic       ev_lvdd, ev_lbat85, ev_lbat75, ev_osc_stop, ev_dst, ev_month, busy_in;
  logic [7:0] status;
  logic       alarm_irq;
  int         n_run  = 0;
  int         n_fail = 0;
  bit         done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_status i_rtc_alarm_status (
    .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .cur_month(cur_month), .cur_wday(cur_wday),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rd_done(bus_rd_done),
    .ev_lvdd(ev_lvdd), .ev_lbat85(ev_lbat85), .ev_lbat75(ev_lbat75),
    .ev_osc_stop(ev_osc_stop), .ev_dst(ev_dst), .ev_month(ev_month),
    .busy_in(busy_in), .status(status), .alarm_irq(alarm_irq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic tick();
    tick_sec = 1'b1; step(); tick_sec = 1'b0;
  endtask

  task automatic rd_open();
    bus_addr = 6'h07; bus_rd = 1'b1; step(); bus_rd = 1'b0;
  endtask

  task automatic rd_close();
    bus_rd_done = 1'b1; step(); bus_rd_done = 1'b0;
  endtask

  task automatic clean();
    wr(6'h07, 8'h00);
    rd_open();
    rd_close();
  endtask

  task automatic t_reset();
    chk("R1", "status after reset", status, 8'h01);
    chk("R1", "irq after reset", {7'd0, alarm_irq}, 8'h00);
  endtask

  task automatic t_rtc_fail();
    wr(6'h10, 8'h00);
    chk("R9", "fail kept on non-time write", status, 8'h01);
    wr(6'h03, 8'h12);
    chk("R9", "fail cleared by time write", status, 8'h00);
  endtask

  task automatic t_match();
    cur_sec = 7'h30; cur_min = 7'h15; cur_hour = 7'h08;
    cur_date = 7'h21; cur_month = 7'h06; cur_wday = 7'h03;
    wr(6'h10, 8'hB0);
    wr(6'h11, 8'h95);
    chk("R3", "no alarm without tick", status, 8'h00);
    tick();
    chk("R2", "alarm on match", status, 8'h10);
    wr(6'h07, 8'h00);
    cur_min = 7'h16; tick();
    chk("R3", "enabled field differs", status, 8'h00);
    cur_min = 7'h15; cur_hour = 7'h11; tick();
    chk("R3", "disabled hour ignored", status, 8'h10);
    wr(6'h07, 8'h00);
    wr(6'h15, 8'h83); tick();
    chk("R2", "weekday field matches", status, 8'h10);
    wr(6'h07, 8'h00);
    cur_wday = 7'h04; tick();
    chk("R3", "weekday field differs", status, 8'h00);
    wr(6'h15, 8'h03);
    wr(6'h10, 8'h30); wr(6'h11, 8'h15); tick();
    chk("R3", "no field enabled", status, 8'h00);
    wr(6'h10, 8'hB0); wr(6'h11, 8'h95);
  endtask

  task automatic t_write();
    ev_dst = 1'b1; step(); ev_dst = 1'b0;
    tick();
    chk("R4", "alarm and dst set", status, 8'h30);
    wr(6'h07, 8'hFF);
    chk("R4", "write ones keeps", status, 8'h30);
    wr(6'h07, 8'h00);
    chk("R4", "write zero clears alarm not dst", status, 8'h20);
    clean();
    chk("R4", "clean state", status, 8'h00);
  endtask

  task automatic t_auto();
    wr(6'h08, 8'h00);
    ev_lvdd = 1'b1; step(); ev_lvdd = 1'b0;
    tick();
    chk("R5", "alarm and lvdd set", status, 8'h18);
    rd_open(); rd_close();
    chk("R5", "auto off keeps flags", status, 8'h18);
    wr(6'h08, 8'h80);
    rd_open();
    chk("R5", "no clear on read strobe", status, 8'h18);
    rd_close();
    chk("R5", "auto on clears on completion", status, 8'h00);
  endtask

  task automatic t_during();
    ev_lvdd = 1'b1; step(); ev_lvdd = 1'b0;
    rd_open();
    tick_sec = 1'b1; ev_lbat85 = 1'b1; step(); tick_sec = 1'b0; ev_lbat85 = 1'b0;
    chk("R6", "flags during read", status, 8'h1C);
    rd_close();
    chk("R6", "mid-read events kept", status, 8'h14);
    clean();
    ev_lbat75 = 1'b1; step(); ev_lbat75 = 1'b0;
    rd_open();
    bus_rd_done = 1'b1; ev_lbat75 = 1'b1; step();
    bus_rd_done = 1'b0; ev_lbat75 = 1'b0;
    chk("R6", "event on completion cycle kept", status, 8'h02);
    clean();
  endtask

  task automatic t_dst();
    wr(6'h08, 8'h00);
    ev_dst = 1'b1; step(); ev_dst = 1'b0;
    chk("R7", "dst set", status, 8'h20);
    rd_open();
    chk("R7", "dst held on read strobe", status, 8'h20);
    rd_close();
    chk("R7", "dst cleared by read", status, 8'h00);
    ev_dst = 1'b1; step(); ev_dst = 1'b0;
    ev_month = 1'b1; step(); ev_month = 1'b0;
    chk("R7", "dst cleared by month", status, 8'h00);
  endtask

  task automatic t_irq();
    tick();
    chk("R8", "irq off without enable", {7'd0, alarm_irq}, 8'h00);
    wr(6'h08, 8'h40);
    chk("R8", "irq on", {7'd0, alarm_irq}, 8'h01);
    wr(6'h07, 8'h00);
    chk("R8", "irq drops with alarm", {7'd0, alarm_irq}, 8'h00);
    wr(6'h08, 8'h00);
  endtask

  task automatic t_events();
    busy_in = 1'b1; #1;
    chk("R10", "busy follows input", status, 8'h80);
    busy_in = 1'b0;
    ev_osc_stop = 1'b1; step(); ev_osc_stop = 1'b0;
    ev_lbat75 = 1'b1; step(); ev_lbat75 = 1'b0;
    step();
    chk("R10", "osc and lbat75 sticky", status, 8'h42);
    wr(6'h07, 8'hBF);
    chk("R10", "osc cleared by write", status, 8'h02);
    clean();
  endtask

  task automatic t_collide();
    ev_lvdd = 1'b1; bus_addr = 6'h07; bus_wdata = 8'h00; bus_wr = 1'b1;
    step();
    ev_lvdd = 1'b0; bus_wr = 1'b0;
    chk("R11", "set beats write clear", status, 8'h08);
    ev_dst = 1'b1; ev_month = 1'b1; step(); ev_dst = 1'b0; ev_month = 1'b0;
    chk("R11", "set beats month clear", status, 8'h28);
    clean();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; tick_sec = 1'b0;
    cur_sec = '0; cur_min = '0; cur_hour = '0; cur_date = '0; cur_month = '0; cur_wday = '0;
    bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_rd_done = 1'b0;
    ev_lvdd = 1'b0; ev_lbat85 = 1'b0; ev_lbat75 = 1'b0; ev_osc_stop = 1'b0;
    ev_dst = 1'b0; ev_month = 1'b0; busy_in = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_rtc_fail();
    t_match();
    t_write();
    t_auto();
    t_during();
    t_dst();
    t_irq();
    t_events();
    t_collide();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule